// File: doc/BRIEF.md
# Instruction Cache Array Access Port

This block lets a bus master reach straight into the storage of a two-way, 256-set instruction cache with 32-byte lines, using ordinary 32-bit loads and stores. The top byte of the address picks the target. One value selects the line data storage and another selects the tag storage. Any other value maps to nothing. Within the selected storage, the lower address bits name the way, the set and, for line data, the longword inside the line.

Stores to the tag storage come in two kinds. A plain store writes a tag and a valid flag into the way the address names. An associative store ignores the way bit in the address. It compares the supplied tag against both ways of the set. Every way that holds that tag with its valid flag set takes the new valid flag. A miss changes nothing and reports nothing, so software can use this store to drop one cached line without knowing which way holds it. Tags are handled as physical addresses, and the fetch path is not part of the block.

Every request completes in a single cycle. A read answers on the following cycle with registered data.

Top module: `icache_map_port`

## Requirements
- R1: While `rst` is high at a clock edge, every tag and valid flag in both ways is cleared to zero, and `rsp_valid` and `err_sticky` are driven low.
- R2: A store whose address bits [31:24] are 0xF1 writes `req_wdata` into line data. Address bit 13 selects the way, bits [12:5] select the set and bits [4:2] select the longword. A read to the same address returns that word.
- R3: A store with address bits [31:24] equal to 0xF0 and address bit 3 low is a plain tag store. It writes `req_wdata[31:10]` as the tag and `req_wdata[0]` as the valid flag into the way given by bit 13 and the set given by bits [12:5].
- R4: A read with address bits [31:24] equal to 0xF0 returns the addressed tag in bits [31:10] and the valid flag in bit 0. Bits [9:1] are always zero.
- R5: A store with address bits [31:24] equal to 0xF0 and address bit 3 high is associative and does not use address bit 13. If a way of the addressed set holds a tag equal to `req_wdata[31:10]` and its valid flag is 1, that way's valid flag becomes `req_wdata[0]`. Its tag is left unchanged.
- R6: An associative store whose tag matches no way, or matches only a way whose valid flag is 0, leaves both ways unchanged and does not set `err_sticky`.
- R7: If both ways of the set match with their valid flags set, an associative store updates the valid flag of both ways.
- R8: A store with address bits [1:0] not equal to zero changes no storage and sets `err_sticky`. The flag stays high until reset.
- R9: If address bits [31:24] are neither 0xF0 nor 0xF1, a store changes no storage and a read returns zero.
- R10: `req_ready` is always high. `rsp_valid` is high exactly on the cycle after an accepted read, and never after a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present |
| req_ready | output | 1 | The block accepts the request (always high) |
| req_write | input | 1 | 1 for a store, 0 for a read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Data for a store |
| rsp_valid | output | 1 | Read data is available |
| rsp_rdata | output | 32 | Registered read data |
| err_sticky | output | 1 | Set by a misaligned store; cleared only by reset |

## Verification
The hardest case to reach from the ports is an associative store where the address points at one way but the matching, valid tag sits in the other way. In the same family are the case where both ways hold the same valid tag and the case where the tag matches but the valid flag is already clear. The stimulus builds each of these states with plain tag stores that give chosen sets chosen tags in both ways. It then issues associative stores whose way bit deliberately points at the wrong way. Finally it reads both ways back through the tag storage to show which valid flags changed and which tags stayed.

// File: rtl/icmap_pkg.sv
package icmap_pkg;

    localparam int WAY_BITS   = 1;
    localparam int NUM_WAYS   = 1 << WAY_BITS;
    localparam int SET_BITS   = 8;
    localparam int NUM_SETS   = 1 << SET_BITS;
    localparam int WORD_BITS  = 3;
    localparam int TAG_W      = 22;
    localparam int DATA_W     = 32;
    localparam int DATA_DEPTH = NUM_WAYS * NUM_SETS * (1 << WORD_BITS);
    localparam int DIDX_W     = WAY_BITS + SET_BITS + WORD_BITS;

    localparam logic [7:0] SEL_TAG  = 8'hF0;
    localparam logic [7:0] SEL_DATA = 8'hF1;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_TAG  = 2'd1,
        TGT_DATA = 2'd2
    } target_e;

    typedef struct packed {
        target_e               target;
        logic [WAY_BITS-1:0]   way;
        logic [SET_BITS-1:0]   set_idx;
        logic [WORD_BITS-1:0]  word;
        logic                  assoc;
        logic                  aligned;
    } req_dec_t;

    function automatic target_e pick_target(input logic [7:0] sel);
        case (sel)
            SEL_TAG:  return TGT_TAG;
            SEL_DATA: return TGT_DATA;
            default:  return TGT_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_tag_word(input logic [TAG_W-1:0] t,
                                                        input logic v);
        return {t, {(DATA_W-TAG_W-1){1'b0}}, v};
    endfunction

endpackage

// File: rtl/icmap_decode.sv
module icmap_decode
    import icmap_pkg::*;
(
    input  logic [31:0] addr,
    output req_dec_t    dec
);
    localparam int WORD_LSB = 2;
    localparam int SET_LSB  = WORD_LSB + WORD_BITS;
    localparam int WAY_LSB  = SET_LSB + SET_BITS;

    logic unused_addr_bits;
    assign unused_addr_bits = ^addr[23:WAY_LSB+WAY_BITS];

    always_comb begin
        dec.target  = pick_target(addr[31:24]);
        dec.way     = addr[WAY_LSB +: WAY_BITS];
        dec.set_idx = addr[SET_LSB +: SET_BITS];
        dec.word    = addr[WORD_LSB +: WORD_BITS];
        dec.assoc   = addr[3];
        dec.aligned = (addr[1:0] == 2'b00);
    end
endmodule

// File: rtl/icmap_tag_store.sv
module icmap_tag_store
    import icmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                plain_we,
    input  logic                assoc_we,
    input  logic [WAY_BITS-1:0] way,
    input  logic [SET_BITS-1:0] set_idx,
    input  logic [TAG_W-1:0]    wtag,
    input  logic                wvld,
    output logic [TAG_W-1:0]    rd_tag,
    output logic                rd_vld
);
    logic [TAG_W-1:0] way_tag [NUM_WAYS];
    logic             way_vld [NUM_WAYS];

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        logic [TAG_W-1:0]    tag_q [NUM_SETS];
        logic [NUM_SETS-1:0] vld_q;
        logic                hit;

        assign hit        = vld_q[set_idx] && (tag_q[set_idx] == wtag);
        assign way_tag[g] = tag_q[set_idx];
        assign way_vld[g] = vld_q[set_idx];

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
                for (int e = 0; e < NUM_SETS; e++) tag_q[e] <= '0;
            end else if (plain_we && (way == WAY_BITS'(g))) begin
                tag_q[set_idx] <= wtag;
                vld_q[set_idx] <= wvld;
            end else if (assoc_we && hit) begin
                vld_q[set_idx] <= wvld;
            end
        end
    end

    assign rd_tag = way_tag[way];
    assign rd_vld = way_vld[way];
endmodule

// File: rtl/icmap_data_store.sv
module icmap_data_store
    import icmap_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [DIDX_W-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DATA_DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/icache_map_port.sv
module icache_map_port
    import icmap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        err_sticky
);
    req_dec_t          dec;
    logic              fire_wr, fire_rd, good_wr;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_vld;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rd_mux;

    icmap_decode u_dec (.addr(req_addr), .dec(dec));

    assign req_ready = 1'b1;
    assign fire_wr   = req_valid && req_write;
    assign fire_rd   = req_valid && !req_write;
    assign good_wr   = fire_wr && dec.aligned;

    icmap_tag_store u_tags (
        .clk     (clk),
        .rst     (rst),
        .plain_we(good_wr && dec.target == TGT_TAG && !dec.assoc),
        .assoc_we(good_wr && dec.target == TGT_TAG &&  dec.assoc),
        .way     (dec.way),
        .set_idx (dec.set_idx),
        .wtag    (req_wdata[DATA_W-1 -: TAG_W]),
        .wvld    (req_wdata[0]),
        .rd_tag  (rd_tag),
        .rd_vld  (rd_vld)
    );

    icmap_data_store u_data (
        .clk  (clk),
        .we   (good_wr && dec.target == TGT_DATA),
        .idx  ({dec.way, dec.set_idx, dec.word}),
        .wdata(req_wdata),
        .rdata(rd_word)
    );

    always_comb begin
        case (dec.target)
            TGT_TAG:  rd_mux = pack_tag_word(rd_tag, rd_vld);
            TGT_DATA: rd_mux = rd_word;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            err_sticky <= 1'b0;
        end else begin
            rsp_valid <= fire_rd;
            if (fire_rd) rsp_rdata <= rd_mux;
            if (fire_wr && !dec.aligned) err_sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/icmap_checker.sv
module icmap_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic [31:0] req_wdata,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        err_sticky
);
    logic rd_acc, bad_wr, unmapped;
    assign rd_acc   = req_valid && req_ready && !req_write;
    assign bad_wr   = req_valid && req_ready && req_write && (req_addr[1:0] != 2'b00);
    assign unmapped = (req_addr[31:24] != 8'hF0) && (req_addr[31:24] != 8'hF1);

    a_r10_always_ready: assert property (@(posedge clk) disable iff (rst) req_ready);
    a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_acc |=> rsp_valid);
    a_r10_no_rsp_otherwise: assert property (@(posedge clk) disable iff (rst)
        !rd_acc |=> !rsp_valid);
    a_r8_err_set: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> err_sticky);
    a_r8_err_holds: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);
    a_r6_no_err_aligned: assert property (@(posedge clk) disable iff (rst)
        (!err_sticky && !bad_wr) |=> !err_sticky);
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && unmapped) |=> (rsp_rdata == 32'h0));
    a_r4_tag_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && req_addr[31:24] == 8'hF0) |=> (rsp_rdata[9:1] == 9'h0));
endmodule

bind icache_map_port icmap_checker u_chk (.*);

// File: tb/tb_icache_map_port.sv
module tb_icache_map_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        err_sticky;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    icache_map_port dut (.*);

    function automatic logic [31:0] taddr(input bit w, input int e, input bit a);
        return {8'hF0, 10'h0, w, 8'(e), 1'b0, a, 3'b000};
    endfunction

    function automatic logic [31:0] daddr(input bit w, input int e, input int lw);
        return {8'hF1, 10'h0, w, 8'(e), 3'(lw), 2'b00};
    endfunction

    function automatic logic [31:0] tword(input logic [21:0] t, input bit v);
        return {t, 9'h0, v};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected response", 32'h1, 32'h0);
            end else begin
                string r;
                logic [31:0] e;
                e = exp_q.pop_front();
                r = tag_q.pop_front();
                check(r, rsp_rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        check("R1 err_sticky after reset", {31'h0, err_sticky}, 32'h0);
        check("R10 req_ready high", {31'h0, req_ready}, 32'h1);
        rd(taddr(0, 0, 0), 32'h0, "R1 tag w0 s0 cleared");
        rd(taddr(1, 255, 0), 32'h0, "R1 tag w1 s255 cleared");

        // R2 line data
        for (int i = 0; i < 8; i++) wr(daddr(0, 3, i), 32'hA000_0000 + i);
        wr(daddr(1, 3, 5), 32'h5555_1111);
        wr(daddr(1, 255, 7), 32'hDEAD_BEEF);
        for (int i = 0; i < 8; i++) rd(daddr(0, 3, i), 32'hA000_0000 + i, "R2 data w0 s3");
        rd(daddr(1, 3, 5), 32'h5555_1111, "R2 data w1 s3 lw5");
        rd(daddr(1, 255, 7), 32'hDEAD_BEEF, "R2 data w1 s255 lw7");

        // R3 / R4 plain tag stores, pad bits in write data must not read back
        wr(taddr(0, 10, 0), tword(22'h12345, 1) | 32'h3FE);
        wr(taddr(1, 10, 0), tword(22'h2ABCD, 1));
        rd(taddr(0, 10, 0), tword(22'h12345, 1), "R3 R4 tag w0 s10");
        rd(taddr(1, 10, 0), tword(22'h2ABCD, 1), "R3 tag w1 s10");

        // R5 associative store, way bit points at way 1, match is in way 0
        wr(taddr(1, 10, 1), tword(22'h12345, 0));
        rd(taddr(0, 10, 0), tword(22'h12345, 0), "R5 assoc clears w0");
        rd(taddr(1, 10, 0), tword(22'h2ABCD, 1), "R5 assoc leaves w1");

        // R6 miss, and match on invalid way
        wr(taddr(0, 10, 1), tword(22'h3FFFF, 0));
        rd(taddr(1, 10, 0), tword(22'h2ABCD, 1), "R6 miss leaves w1");
        wr(taddr(1, 10, 1), tword(22'h12345, 1));
        rd(taddr(0, 10, 0), tword(22'h12345, 0), "R6 invalid match no set");
        check("R6 no error on assoc miss", {31'h0, err_sticky}, 32'h0);

        // R7 both ways match
        wr(taddr(0, 20, 0), tword(22'h0F0F0, 1));
        wr(taddr(1, 20, 0), tword(22'h0F0F0, 1));
        wr(taddr(0, 20, 1), tword(22'h0F0F0, 0));
        rd(taddr(0, 20, 0), tword(22'h0F0F0, 0), "R7 both w0");
        rd(taddr(1, 20, 0), tword(22'h0F0F0, 0), "R7 both w1");

        // R9 unmapped
        wr({8'hF2, daddr(0, 3, 0) & 32'h00FF_FFFF}, 32'h0BAD_0BAD);
        rd({8'hF2, daddr(0, 3, 0) & 32'h00FF_FFFF}, 32'h0, "R9 unmapped read zero");
        rd(daddr(0, 3, 0), 32'hA000_0000, "R9 unmapped store ignored");

        // R8 misaligned store
        check("R8 err low before", {31'h0, err_sticky}, 32'h0);
        wr(daddr(0, 3, 1) | 32'h1, 32'hFFFF_FFFF);
        rd(daddr(0, 3, 1), 32'hA000_0001, "R8 misaligned ignored");
        check("R8 err set", {31'h0, err_sticky}, 32'h1);
        wr(daddr(0, 3, 2), 32'h7777_7777);
        rd(daddr(0, 3, 2), 32'h7777_7777, "R2 aligned after error");
        check("R8 err stays", {31'h0, err_sticky}, 32'h1);

        repeat (3) @(negedge clk);
        check("R10 all reads answered", exp_q.size(), 32'h0);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 err cleared by reset", {31'h0, err_sticky}, 32'h0);
        rd(taddr(1, 10, 0), 32'h0, "R1 tag cleared by reset");
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule